// File: doc/BRIEF.md
# Byte-Wide I2C Target Controller

This block is the target (slave) side of an I2C link with a small register interface for a local processor. It watches the open-drain clock and data lines through a synchroniser. It recognises start, repeated-start and stop conditions. It compares the first byte of each transfer with its own 7-bit address, and with the general-call address when that option is built in. It acknowledges by pulling the data line low, and it moves bytes most significant bit first through a shift register that the processor cannot address.

The processor sees three locations. The data location holds the byte last received or the byte queued for sending. The status location is read-only and holds six interrupt causes plus two qualifier flags. The control location holds the two interrupt enables and a self-clearing flush command. The interrupt output is the enabled OR of the causes. A typical use is to answer the address-match interrupt, read or fill the data location on each receive-full or transmit-empty interrupt, drop the transmit enable and flush when the controller reports a not-acknowledge, and clear the stop/restart flag when the transfer ends.

Top module: `i2c_slave_ctl`

## Requirements
- R1: After reset, data reads 0x00, status reads 0x01 (only transmit-empty, bit 0), control reads 0x00, `irq` is low and the controller does not pull SDA.
- R2: When the 7 address bits after a start equal `own_addr`, the controller pulls SDA low for the ninth clock, sets address-match (status bit 2) and copies the read/write bit into direction (status bit 7). Any other address is neither acknowledged nor flagged.
- R3: Address 0x00 with the write bit is acknowledged as a general call: it sets address-match and general-call (status bit 6). An ordinary address match clears general-call.
- R4: Written bytes are taken in MSB first and acknowledged. At the end of each byte the byte is copied into data (select 0) and receive-full (status bit 1) is set. A read of data clears receive-full.
- R5: A processor write to data made while a slave-write byte is being received changes neither data nor transmit-empty.
- R6: In a read transfer the byte in data is sent MSB first and transmit-empty is set when the byte is taken. A processor write to data clears transmit-empty. While transmit-empty is set, 0xFF is sent.
- R7: A not-acknowledge from the master after a sent byte sets NAK (status bit 5), and the controller leaves SDA released.
- R8: A stop or repeated start after the controller was addressed sets stop/restart (status bit 4). Writing status with bit 4 at 1 clears it. Bits 2 to 5 clear the same way when written as 1.
- R9: Writing control with bit 1 at 1 flushes the queued transmit byte and sets transmit-empty. Control bit 1 reads back as 0.
- R10: `irq` is high when (control bit 2 is set and any of status bits 1 to 5 is set) or (control bit 0 is set and transmit-empty is set).
- R11: When the controller leaves SDA released to send a 1 and samples SDA low on the rising clock, it sets arbitration-lost (status bit 3).
- R12: A hardware event that sets a status bit wins over a processor clear or read of that bit in the same clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sensed SCL line level |
| sda_i | input | 1 | Sensed SDA line level |
| sda_oe | output | 1 | High pulls SDA low (open drain) |
| own_addr | input | ADDR_W | Own 7-bit target address |
| bus_sel | input | 2 | Register select: 0 data, 1 status, 2 control |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for the selected register |
| irq | output | 1 | Interrupt request |

## Verification
The end of a received byte, which sets receive-full, and a processor read of the data location, which clears it, can fall in the same clock cycle. The bench counts the synchroniser stages and the event register from the falling SCL edge of the eighth bit, and holds the read strobe so that it is sampled on exactly the edge where receive-full is set. It then judges that receive-full is still set and that the new byte can be read. The stop/restart set against its write-one clear is covered by an assertion next to the status register.

// File: rtl/i2cs_pkg.sv
`timescale 1ns/1ps
package i2cs_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_AACK,
      ST_RX,
      ST_RACK,
      ST_TX,
      ST_TACK,
      ST_TLOAD
   } eng_st_t;

   localparam logic [1:0] SEL_DATA = 2'd0;
   localparam logic [1:0] SEL_STAT = 2'd1;
   localparam logic [1:0] SEL_CTL  = 2'd2;

   localparam int SB_TXE = 0;
   localparam int SB_RXF = 1;
   localparam int SB_AM  = 2;
   localparam int SB_ARB = 3;
   localparam int SB_SPR = 4;
   localparam int SB_NAK = 5;
   localparam int SB_GC  = 6;
   localparam int SB_DIR = 7;

   localparam int CB_TXIE  = 0;
   localparam int CB_FLUSH = 1;
   localparam int CB_IEN   = 2;

endpackage

// File: rtl/i2cs_line_sync.sv
`timescale 1ns/1ps
module i2cs_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_ev,
   output logic stop_ev
);

   logic [STAGES-1:0] scl_ch, sda_ch;
   logic              scl_prev, sda_prev;
   logic              scl_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_ch   <= '1;
         sda_ch   <= '1;
         scl_prev <= 1'b1;
         sda_prev <= 1'b1;
      end else begin
         scl_ch   <= {scl_ch[STAGES-2:0], scl_i};
         sda_ch   <= {sda_ch[STAGES-2:0], sda_i};
         scl_prev <= scl_ch[STAGES-1];
         sda_prev <= sda_ch[STAGES-1];
      end
   end

   assign scl_s    = scl_ch[STAGES-1];
   assign sda_s    = sda_ch[STAGES-1];
   assign scl_rise = scl_s & ~scl_prev;
   assign scl_fall = ~scl_s & scl_prev;
   assign start_ev = scl_s & scl_prev & ~sda_s & sda_prev;
   assign stop_ev  = scl_s & scl_prev & sda_s & ~sda_prev;

endmodule

// File: rtl/i2cs_engine.sv
`timescale 1ns/1ps
module i2cs_engine
   import i2cs_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 7,
   parameter bit GC_EN  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_ev,
   input  logic              stop_ev,
   input  logic              sda_s,
   input  logic [ADDR_W-1:0] own_addr,
   input  logic [DATA_W-1:0] tx_byte,
   output logic              sda_oe,
   output logic              rx_busy,
   output logic              tx_take,
   output logic              ev_addr,
   output logic              ev_gc,
   output logic              ev_rd,
   output logic              ev_rx,
   output logic [DATA_W-1:0] rx_byte,
   output logic              ev_nak,
   output logic              ev_arb,
   output logic              ev_sprs
);

   localparam int CW = $clog2(DATA_W + 1);

   eng_st_t           st;
   logic [CW-1:0]     cnt;
   logic [DATA_W-1:0] sh;
   logic              rd_q, engaged;
   logic              byte_done, match_own, match_gc, hit;

   assign byte_done = (cnt == CW'(DATA_W));
   assign match_own = (sh[DATA_W-1:1] == own_addr);

   generate
      if (GC_EN) begin : g_gc
         assign match_gc = (sh[DATA_W-1:1] == '0) && !sh[0];
      end else begin : g_no_gc
         assign match_gc = 1'b0;
      end
   endgenerate

   assign hit     = (st == ST_ADDR) && scl_fall && byte_done && (match_own || match_gc);
   assign tx_take = (hit && sh[0]) || ((st == ST_TACK) && scl_rise && !sda_s);
   assign rx_busy = (st == ST_RX) || (st == ST_RACK);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         cnt     <= '0;
         sh      <= '0;
         rd_q    <= 1'b0;
         engaged <= 1'b0;
         sda_oe  <= 1'b0;
         ev_addr <= 1'b0;
         ev_gc   <= 1'b0;
         ev_rd   <= 1'b0;
         ev_rx   <= 1'b0;
         rx_byte <= '0;
         ev_nak  <= 1'b0;
         ev_arb  <= 1'b0;
         ev_sprs <= 1'b0;
      end else begin
         ev_addr <= 1'b0;
         ev_rx   <= 1'b0;
         ev_nak  <= 1'b0;
         ev_arb  <= 1'b0;
         ev_sprs <= 1'b0;
         if (start_ev) begin
            st      <= ST_ADDR;
            cnt     <= '0;
            sda_oe  <= 1'b0;
            ev_sprs <= engaged;
            engaged <= 1'b0;
         end else if (stop_ev) begin
            st      <= ST_IDLE;
            sda_oe  <= 1'b0;
            ev_sprs <= engaged;
            engaged <= 1'b0;
         end else begin
            case (st)
               ST_ADDR: begin
                  if (scl_rise && !byte_done) begin
                     sh  <= {sh[DATA_W-2:0], sda_s};
                     cnt <= cnt + CW'(1);
                  end else if (scl_fall && byte_done) begin
                     if (hit) begin
                        sda_oe  <= 1'b1;
                        st      <= ST_AACK;
                        ev_addr <= 1'b1;
                        ev_gc   <= match_gc;
                        ev_rd   <= sh[0];
                        rd_q    <= sh[0];
                        engaged <= 1'b1;
                        if (sh[0]) sh <= tx_byte;
                     end else begin
                        st <= ST_IDLE;
                     end
                  end
               end
               ST_AACK: begin
                  if (scl_fall) begin
                     cnt <= '0;
                     if (rd_q) begin
                        st     <= ST_TX;
                        sda_oe <= ~sh[DATA_W-1];
                     end else begin
                        st     <= ST_RX;
                        sda_oe <= 1'b0;
                     end
                  end
               end
               ST_RX: begin
                  if (scl_rise && !byte_done) begin
                     sh  <= {sh[DATA_W-2:0], sda_s};
                     cnt <= cnt + CW'(1);
                  end else if (scl_fall && byte_done) begin
                     ev_rx   <= 1'b1;
                     rx_byte <= sh;
                     sda_oe  <= 1'b1;
                     st      <= ST_RACK;
                  end
               end
               ST_RACK: begin
                  if (scl_fall) begin
                     sda_oe <= 1'b0;
                     cnt    <= '0;
                     st     <= ST_RX;
                  end
               end
               ST_TX: begin
                  if (scl_rise) begin
                     cnt <= cnt + CW'(1);
                     if (!sda_oe && !sda_s) ev_arb <= 1'b1;
                  end else if (scl_fall && byte_done) begin
                     sda_oe <= 1'b0;
                     st     <= ST_TACK;
                  end else if (scl_fall) begin
                     sh     <= sh << 1;
                     sda_oe <= ~sh[DATA_W-2];
                  end
               end
               ST_TACK: begin
                  if (scl_rise) begin
                     if (!sda_s) begin
                        sh <= tx_byte;
                        st <= ST_TLOAD;
                     end else begin
                        ev_nak <= 1'b1;
                        st     <= ST_IDLE;
                     end
                  end
               end
               ST_TLOAD: begin
                  if (scl_fall) begin
                     cnt    <= '0;
                     st     <= ST_TX;
                     sda_oe <= ~sh[DATA_W-1];
                  end
               end
               default: ;
            endcase
         end
      end
   end

   // R2: an accepted address is acknowledged from the same edge on
   assert_ack_drive_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ev_addr |-> sda_oe);

   // R7: a released ninth bit after a sent byte raises NAK and keeps SDA free
   assert_nak_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_TACK && scl_rise && sda_s && !start_ev && !stop_ev) |=> (ev_nak && !sda_oe));

endmodule

// File: rtl/i2cs_regs.sv
`timescale 1ns/1ps
module i2cs_regs
   import i2cs_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        bus_sel,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              rx_busy,
   input  logic              tx_take,
   input  logic              ev_addr,
   input  logic              ev_gc,
   input  logic              ev_rd,
   input  logic              ev_rx,
   input  logic [DATA_W-1:0] rx_byte,
   input  logic              ev_nak,
   input  logic              ev_arb,
   input  logic              ev_sprs,
   output logic [DATA_W-1:0] tx_byte,
   output logic              irq
);

   logic [DATA_W-1:0] data_q, stat_v, ctl_v;
   logic txe_q, rxf_q, am_q, arb_q, spr_q, nak_q, gc_q, dir_q;
   logic txie_q, ien_q, flush_q;
   logic wr_data, wr_ok, wr_stat, wr_ctl, rd_data;

   assign wr_data = bus_wr && (bus_sel == SEL_DATA);
   assign wr_ok   = wr_data && !rx_busy;
   assign wr_stat = bus_wr && (bus_sel == SEL_STAT);
   assign wr_ctl  = bus_wr && (bus_sel == SEL_CTL);
   assign rd_data = bus_rd && (bus_sel == SEL_DATA);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q  <= '0;
         txe_q   <= 1'b1;
         rxf_q   <= 1'b0;
         am_q    <= 1'b0;
         arb_q   <= 1'b0;
         spr_q   <= 1'b0;
         nak_q   <= 1'b0;
         gc_q    <= 1'b0;
         dir_q   <= 1'b0;
         txie_q  <= 1'b0;
         ien_q   <= 1'b0;
         flush_q <= 1'b0;
      end else begin
         if (ev_rx)      data_q <= rx_byte;
         else if (wr_ok) data_q <= bus_wdata;

         if (wr_ok)                   txe_q <= 1'b0;
         else if (flush_q || tx_take) txe_q <= 1'b1;

         if (ev_rx)        rxf_q <= 1'b1;
         else if (rd_data) rxf_q <= 1'b0;

         if (ev_addr)                          am_q <= 1'b1;
         else if (wr_stat && bus_wdata[SB_AM]) am_q <= 1'b0;
         if (ev_arb)                            arb_q <= 1'b1;
         else if (wr_stat && bus_wdata[SB_ARB]) arb_q <= 1'b0;
         if (ev_sprs)                           spr_q <= 1'b1;
         else if (wr_stat && bus_wdata[SB_SPR]) spr_q <= 1'b0;
         if (ev_nak)                            nak_q <= 1'b1;
         else if (wr_stat && bus_wdata[SB_NAK]) nak_q <= 1'b0;

         if (ev_addr) begin
            gc_q  <= ev_gc;
            dir_q <= ev_rd;
         end

         if (wr_ctl) begin
            txie_q <= bus_wdata[CB_TXIE];
            ien_q  <= bus_wdata[CB_IEN];
         end
         flush_q <= wr_ctl && bus_wdata[CB_FLUSH];
      end
   end

   always_comb begin
      stat_v         = '0;
      stat_v[SB_TXE] = txe_q;
      stat_v[SB_RXF] = rxf_q;
      stat_v[SB_AM]  = am_q;
      stat_v[SB_ARB] = arb_q;
      stat_v[SB_SPR] = spr_q;
      stat_v[SB_NAK] = nak_q;
      stat_v[SB_GC]  = gc_q;
      stat_v[SB_DIR] = dir_q;
      ctl_v           = '0;
      ctl_v[CB_TXIE]  = txie_q;
      ctl_v[CB_FLUSH] = flush_q;
      ctl_v[CB_IEN]   = ien_q;
      case (bus_sel)
         SEL_DATA: bus_rdata = data_q;
         SEL_STAT: bus_rdata = stat_v;
         SEL_CTL:  bus_rdata = ctl_v;
         default:  bus_rdata = '0;
      endcase
   end

   assign tx_byte = txe_q ? '1 : data_q;
   assign irq     = (ien_q && (rxf_q || am_q || arb_q || spr_q || nak_q)) || (txie_q && txe_q);

   // R5: processor writes during slave-write reception leave data untouched
   assert_blocked_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_data && rx_busy && !ev_rx) |=> (data_q == $past(data_q)));

   // R12: byte completion beats a same-cycle read of data
   assert_rx_set_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
      ev_rx |=> rxf_q);

   // R8: stop/restart detection beats a same-cycle write-one clear
   assert_stop_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ev_sprs |=> spr_q);

   // R9: a flush empties the transmit slot unless a new byte lands
   assert_flush_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_q && !wr_ok) |=> txe_q);

endmodule

// File: rtl/i2c_slave_ctl.sv
`timescale 1ns/1ps
module i2c_slave_ctl #(
   parameter int DATA_W      = 8,
   parameter int ADDR_W      = 7,
   parameter int SYNC_STAGES = 2,
   parameter bit GC_EN       = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe,
   input  logic [ADDR_W-1:0] own_addr,
   input  logic [1:0]        bus_sel,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq
);

   generate
      if (ADDR_W != DATA_W - 1) begin : g_bad_addr_w
         $error("ADDR_W must be one less than DATA_W");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (DATA_W < 8) begin : g_bad_data_w
         $error("DATA_W must be at least 8");
      end
   endgenerate

   logic              sda_s, scl_rise, scl_fall, start_ev, stop_ev;
   logic              rx_busy, tx_take, ev_addr, ev_gc, ev_rd, ev_rx;
   logic              ev_nak, ev_arb, ev_sprs;
   logic [DATA_W-1:0] rx_byte, tx_byte;

   i2cs_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_i    (scl_i),
      .sda_i    (sda_i),
      .sda_s    (sda_s),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .start_ev (start_ev),
      .stop_ev  (stop_ev)
   );

   i2cs_engine #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .GC_EN(GC_EN)) u_eng (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .start_ev (start_ev),
      .stop_ev  (stop_ev),
      .sda_s    (sda_s),
      .own_addr (own_addr),
      .tx_byte  (tx_byte),
      .sda_oe   (sda_oe),
      .rx_busy  (rx_busy),
      .tx_take  (tx_take),
      .ev_addr  (ev_addr),
      .ev_gc    (ev_gc),
      .ev_rd    (ev_rd),
      .ev_rx    (ev_rx),
      .rx_byte  (rx_byte),
      .ev_nak   (ev_nak),
      .ev_arb   (ev_arb),
      .ev_sprs  (ev_sprs)
   );

   i2cs_regs #(.DATA_W(DATA_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .rx_busy   (rx_busy),
      .tx_take   (tx_take),
      .ev_addr   (ev_addr),
      .ev_gc     (ev_gc),
      .ev_rd     (ev_rd),
      .ev_rx     (ev_rx),
      .rx_byte   (rx_byte),
      .ev_nak    (ev_nak),
      .ev_arb    (ev_arb),
      .ev_sprs   (ev_sprs),
      .tx_byte   (tx_byte),
      .irq       (irq)
   );

endmodule

// File: tb/i2c_slave_ctl_bench.sv
`timescale 1ns/1ps
module i2c_slave_ctl_bench;

   localparam int Q = 6;
   localparam logic [6:0] OWN = 7'h2A;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_m = 1'b1, sda_m = 1'b1;
   logic       sda_oe, irq;
   logic [1:0] bus_sel = 2'd0;
   logic       bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0] bus_wdata = 8'h00, bus_rdata;
   logic       sda_line;
   int         n_chk = 0, n_err = 0;
   logic [7:0] exp_q[$];
   logic [7:0] v;
   logic       ak;

   always #2.5 clk = ~clk;
   assign sda_line = sda_m & ~sda_oe;

   i2c_slave_ctl u_i2c_slave_ctl (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
      .own_addr(OWN), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
   );

   task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_err++;
         $display("FAIL %s got=%h exp=%h", req, got, exp);
      end
   endtask

   task automatic qwait();
      repeat (Q) @(negedge clk);
   endtask

   task automatic reg_write(input logic [1:0] sel, input logic [7:0] d);
      @(negedge clk);
      bus_sel = sel; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic reg_read(input logic [1:0] sel, output logic [7:0] d);
      @(negedge clk);
      bus_sel = sel; bus_rd = 1'b1;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic i2c_start();
      sda_m = 1'b1; qwait(); scl_m = 1'b1; qwait();
      sda_m = 1'b0; qwait(); scl_m = 1'b0; qwait();
   endtask

   task automatic i2c_stop();
      sda_m = 1'b0; qwait(); scl_m = 1'b1; qwait();
      sda_m = 1'b1; qwait();
   endtask

   task automatic write_bit(input logic b);
      sda_m = b; qwait(); scl_m = 1'b1; qwait(); qwait(); scl_m = 1'b0; qwait();
   endtask

   task automatic read_bit(output logic b);
      sda_m = 1'b1; qwait(); scl_m = 1'b1; qwait(); b = sda_line; qwait();
      scl_m = 1'b0; qwait();
   endtask

   // driver: sends a byte, optionally pokes data mid-byte, returns the ninth bit
   task automatic send_byte(input logic [7:0] b, input logic poke, output logic a);
      for (int i = 7; i >= 0; i--) begin
         write_bit(b[i]);
         if (poke && i == 4) reg_write(2'd0, 8'h33);
      end
      read_bit(a);
   endtask

   task automatic recv_byte(input logic nak, output logic [7:0] b);
      for (int i = 7; i >= 0; i--) read_bit(b[i]);
      write_bit(nak);
   endtask

   // monitor: reads the data register and compares with the queue head
   task automatic sb_pop(input string req);
      logic [7:0] got, exp;
      reg_read(2'd0, got);
      exp = (exp_q.size() > 0) ? exp_q.pop_front() : 8'hxx;
      chk(req, got, exp);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_err++; n_chk++;
      $display("FAIL watchdog expired (all requirements)");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      // R1 reset state
      reg_read(2'd0, v); chk("R1 data", v, 8'h00);
      reg_read(2'd1, v); chk("R1 status", v, 8'h01);
      reg_read(2'd2, v); chk("R1 control", v, 8'h00);
      chk("R1 irq", {7'd0, irq}, 8'h00);
      chk("R1 sda released", {7'd0, sda_line}, 8'h01);

      // R2 R4 R5 R10 R8: write transfer to own address
      reg_write(2'd2, 8'h04);
      i2c_start();
      send_byte({OWN, 1'b0}, 1'b0, ak); chk("R2 address ack", {7'd0, ak}, 8'h00);
      reg_read(2'd1, v); chk("R2 match flag dir=0", v, 8'h05);
      chk("R10 irq on address match", {7'd0, irq}, 8'h01);
      reg_write(2'd1, 8'h04);
      reg_read(2'd1, v); chk("R8 clear match", v, 8'h01);
      chk("R10 irq cleared", {7'd0, irq}, 8'h00);
      exp_q.push_back(8'hA5);
      send_byte(8'hA5, 1'b1, ak); chk("R4 data ack", {7'd0, ak}, 8'h00);
      reg_read(2'd1, v); chk("R4 receive-full set", v, 8'h03);
      sb_pop("R4 R5 received byte, blocked write");
      reg_read(2'd1, v); chk("R4 R5 rx-full cleared, tx-empty kept", v, 8'h01);
      exp_q.push_back(8'h5C);
      send_byte(8'h5C, 1'b0, ak);
      sb_pop("R4 second byte");
      i2c_stop();
      reg_read(2'd1, v); chk("R8 stop flag", v, 8'h11);
      chk("R10 irq on stop", {7'd0, irq}, 8'h01);
      reg_write(2'd1, 8'h10);
      reg_read(2'd1, v); chk("R8 stop cleared", v, 8'h01);

      // R2 foreign address
      i2c_start();
      send_byte({7'h22, 1'b0}, 1'b0, ak); chk("R2 foreign no ack", {7'd0, ak}, 8'h01);
      i2c_stop();
      reg_read(2'd1, v); chk("R2 foreign no flag", v, 8'h01);

      // R3 general call
      i2c_start();
      send_byte(8'h00, 1'b0, ak); chk("R3 general call ack", {7'd0, ak}, 8'h00);
      reg_read(2'd1, v); chk("R3 general call flags", v, 8'h45);
      exp_q.push_back(8'h77);
      send_byte(8'h77, 1'b0, ak);
      sb_pop("R3 general call byte");
      i2c_stop();
      reg_read(2'd1, v); chk("R3 R8 after stop", v, 8'h55);
      reg_write(2'd1, 8'h14);
      reg_read(2'd1, v); chk("R3 gc kept", v, 8'h41);

      // R6 R7 R9 R10: read transfer
      reg_write(2'd0, 8'h96);
      reg_read(2'd1, v); chk("R6 write clears tx-empty", v, 8'h40);
      reg_write(2'd2, 8'h05);
      chk("R10 no irq", {7'd0, irq}, 8'h00);
      i2c_start();
      send_byte({OWN, 1'b1}, 1'b0, ak); chk("R2 read address ack", {7'd0, ak}, 8'h00);
      reg_read(2'd1, v); chk("R2 R3 R6 dir, gc cleared, taken", v, 8'h85);
      reg_write(2'd1, 8'h04);
      chk("R10 irq from tx-empty", {7'd0, irq}, 8'h01);
      recv_byte(1'b0, v); chk("R6 sent byte", v, 8'h96);
      recv_byte(1'b1, v); chk("R6 empty sends ones", v, 8'hFF);
      reg_read(2'd1, v); chk("R7 nak flag", v, 8'hA1);
      chk("R7 sda released", {7'd0, sda_line}, 8'h01);
      reg_write(2'd0, 8'h44);
      reg_read(2'd1, v); chk("R6 queued", v, 8'hA0);
      reg_write(2'd2, 8'h07);
      repeat (2) @(negedge clk);
      reg_read(2'd1, v); chk("R9 flush sets tx-empty", v, 8'hA1);
      reg_read(2'd2, v); chk("R9 flush reads 0", v, 8'h05);
      i2c_stop();
      reg_read(2'd1, v); chk("R8 stop after read", v, 8'hB1);
      reg_write(2'd1, 8'h30);
      reg_read(2'd1, v); chk("R8 R7 cleared", v, 8'h81);

      // R8 repeated start
      i2c_start();
      send_byte({OWN, 1'b0}, 1'b0, ak);
      reg_write(2'd1, 8'h04);
      exp_q.push_back(8'h12);
      send_byte(8'h12, 1'b0, ak);
      sb_pop("R4 byte before restart");
      i2c_start();
      reg_read(2'd1, v); chk("R8 restart flag", v, 8'h11);
      i2c_stop();
      reg_write(2'd1, 8'h10);

      // R12 byte completion against same-cycle data read
      i2c_start();
      send_byte({OWN, 1'b0}, 1'b0, ak);
      reg_write(2'd1, 8'h04);
      for (int i = 7; i >= 1; i--) write_bit(i[0] ? 1'b0 : 1'b1);
      sda_m = 1'b0; qwait(); scl_m = 1'b1; qwait(); qwait(); scl_m = 1'b0;
      repeat (3) @(negedge clk);
      bus_sel = 2'd0; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      qwait();
      read_bit(ak); chk("R12 ack", {7'd0, ak}, 8'h00);
      reg_read(2'd1, v); chk("R12 set wins over read", v, 8'h03);
      exp_q.push_back(8'h54);
      sb_pop("R12 byte after race");
      i2c_stop();
      reg_write(2'd1, 8'h10);

      // R11 arbitration lost while sending a 1
      i2c_start();
      send_byte({OWN, 1'b1}, 1'b0, ak);
      reg_write(2'd1, 8'h04);
      write_bit(1'b0);
      for (int i = 0; i < 7; i++) read_bit(ak);
      write_bit(1'b1);
      reg_read(2'd1, v); chk("R11 arbitration flag", v, 8'hA9);
      i2c_stop();
      reg_read(2'd1, v); chk("R11 R8 after stop", v, 8'hB9);

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule